// File: doc/BRIEF.md
# Thermal ADC Code to Temperature Converter

This block turns a raw reading from an on-die thermal sensor's ADC into a signed temperature in millidegrees Celsius. A constant table of breakpoints, spaced 5 °C apart, maps falling codes to rising temperatures. A sequential binary search picks the pair of neighbouring breakpoints that surround the reading. The block then interpolates in a straight line between them, using a bit-serial restoring divide.

A client places a code on the input and pulses `start` for one cycle while `busy` is low. Some cycles later `done` pulses for one cycle. In that cycle `temp` carries the result, and `invalid` marks a reading that is out of range. The block accepts no new request until it has answered the current one.

Top module: `thermo_code_interp`

## Requirements
- R1: A request whose `code_in` has any bit at position 12 or above set is out of range. It completes with `done` and `invalid` both high and `temp` equal to 0, in the cycle after `start` is sampled.
- R2: The table has 36 entries, index 0 to 35. Index 0 is a sentinel of code 4095 at −40000. Indices 1 to 34 hold codes 3800, 3792, 3783, 3774, 3765, 3756, 3747, 3737, 3728, 3718, 3708, 3698, 3688, 3678, 3667, 3656, 3645, 3634, 3623, 3611, 3600, 3588, 3575, 3563, 3550, 3537, 3524, 3510, 3496, 3482, 3467, 3452, 3437 and 3421, at temperatures −40000 + (i−1)·5000. Index 35 is a sentinel of code 0 at 125000. A code equal to the code of entry i, for i from 1 to 34, yields exactly that entry's temperature; for example, 3728 gives 0, 3600 gives 60000 and 3496 gives 100000.
- R3: For a valid code, let i be the index with code ≥ c[i] and code < c[i−1]. The result is t[i−1] + (t[i]−t[i−1])·(c[i−1]−code) / (c[i−1]−c[i]), with the division truncated toward zero.
- R4: Codes from 3801 to 4095 inclusive yield −40000. Code 4095 also yields −40000, because the search falls onto the low sentinel.
- R5: Codes from 0 to 3420 inclusive yield 125000.
- R6: Every accepted `start` produces exactly one `done` pulse, one cycle wide, no later than DIV_W+16 cycles after `start` is sampled.
- R7: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` raised while `busy` is high neither changes the pending result nor adds a `done` pulse.
- R8: After reset, `busy`, `done` and `invalid` are low and `temp` is 0.
- R9: A valid result always lies between −40000 and 125000 inclusive.
- R10: `busy` falls in the cycle after `done`. A `start` in that cycle is accepted.

The controller has four states:
- IDLE waits for `start`.
- SEARCH narrows the low and high index bounds by one table probe per cycle.
- DIVIDE waits for the quotient.
- FINISH raises `done` for one cycle.

The transitions are:
- IDLE→FINISH on an out-of-range code.
- IDLE→SEARCH on a valid code.
- SEARCH→DIVIDE when the probe brackets the code.
- SEARCH→FINISH when the probe index reaches 0, which clamps the result to the low sentinel temperature.
- DIVIDE→FINISH when the divider reports completion.
- FINISH→IDLE unconditionally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| code_in | input | IN_W (16) | Raw sensor code; values above 4095 are invalid |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion strobe |
| invalid | output | 1 | With `done`: the code was out of range |
| temp | output | TEMP_W (32) | Signed temperature in millidegrees Celsius |

## Verification
The bench builds the block with its default parameters:
- IN_W of 16 lets the bench drive codes far above the 12-bit range.
- DIV_W of 32 makes every valid conversion take over thirty divide cycles. That leaves a wide window in which to raise a stray `start`.
- The 36-entry table makes the search run six or seven probes, which exercises both sentinels and the fall onto index 0.

Random codes across the whole 16-bit space are mixed with every exact breakpoint and both sentinel edges.

// File: rtl/thermo_interp_pkg.sv
package thermo_interp_pkg;

    localparam int BP_COUNT  = 36;
    localparam int BP_CODE_W = 12;
    localparam int BP_TEMP_W = 32;
    localparam int BP_STEP   = 5000;
    localparam int BP_T_MIN  = -40000;
    localparam int BP_T_MAX  = 125000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_DIVIDE,
        ST_FINISH
    } conv_state_t;

    // Breakpoint code by index; codes fall as the index rises.
    function automatic logic [BP_CODE_W-1:0] bp_code(input int idx);
        case (idx)
            0:  return 12'd4095;
            1:  return 12'd3800;
            2:  return 12'd3792;
            3:  return 12'd3783;
            4:  return 12'd3774;
            5:  return 12'd3765;
            6:  return 12'd3756;
            7:  return 12'd3747;
            8:  return 12'd3737;
            9:  return 12'd3728;
            10: return 12'd3718;
            11: return 12'd3708;
            12: return 12'd3698;
            13: return 12'd3688;
            14: return 12'd3678;
            15: return 12'd3667;
            16: return 12'd3656;
            17: return 12'd3645;
            18: return 12'd3634;
            19: return 12'd3623;
            20: return 12'd3611;
            21: return 12'd3600;
            22: return 12'd3588;
            23: return 12'd3575;
            24: return 12'd3563;
            25: return 12'd3550;
            26: return 12'd3537;
            27: return 12'd3524;
            28: return 12'd3510;
            29: return 12'd3496;
            30: return 12'd3482;
            31: return 12'd3467;
            32: return 12'd3452;
            33: return 12'd3437;
            34: return 12'd3421;
            default: return 12'd0;
        endcase
    endfunction

    // Breakpoint temperature by index, in millidegrees; both sentinels repeat their neighbour.
    function automatic logic signed [BP_TEMP_W-1:0] bp_temp(input int idx);
        if (idx <= 1)
            return BP_TEMP_W'(BP_T_MIN);
        else if (idx >= BP_COUNT - 2)
            return BP_TEMP_W'(BP_T_MAX);
        else
            return BP_TEMP_W'(BP_T_MIN + (idx - 1) * BP_STEP);
    endfunction

endpackage

// File: rtl/tci_bp_rom.sv
module tci_bp_rom
    import thermo_interp_pkg::*;
#(
    parameter int N_BP   = BP_COUNT,
    parameter int CODE_W = BP_CODE_W,
    parameter int TEMP_W = BP_TEMP_W,
    localparam int IDX_W = $clog2(N_BP)
) (
    input  logic [IDX_W-1:0]         idx_a,
    input  logic [IDX_W-1:0]         idx_b,
    output logic [CODE_W-1:0]        code_a,
    output logic signed [TEMP_W-1:0] temp_a,
    output logic [CODE_W-1:0]        code_b,
    output logic signed [TEMP_W-1:0] temp_b
);

    logic [CODE_W-1:0]        code_tab [N_BP];
    logic signed [TEMP_W-1:0] temp_tab [N_BP];

    for (genvar g = 0; g < N_BP; g++) begin : g_entry
        assign code_tab[g] = CODE_W'(bp_code(g));
        assign temp_tab[g] = TEMP_W'(bp_temp(g));
    end

    always_comb begin
        code_a = code_tab[idx_a];
        temp_a = temp_tab[idx_a];
        code_b = code_tab[idx_b];
        temp_b = temp_tab[idx_b];
    end

endmodule

// File: rtl/tci_restoring_div.sv
module tci_restoring_div #(
    parameter int W = 32,
    localparam int CNT_W = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         fin,
    output logic [W-1:0] quotient
);

    logic [W-1:0]     quo_r;
    logic [W-1:0]     dsr_r;
    logic [W:0]       rem_r;
    logic [CNT_W-1:0] cnt_r;
    logic             run_r;
    logic             fin_r;
    logic [W:0]       shifted;
    logic [W+1:0]     trial;

    always_comb begin
        shifted = {rem_r[W-1:0], quo_r[W-1]};
        trial   = {1'b0, shifted} - {2'b00, dsr_r};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_r <= '0;
            dsr_r <= '0;
            rem_r <= '0;
            cnt_r <= '0;
            run_r <= 1'b0;
            fin_r <= 1'b0;
        end else begin
            fin_r <= 1'b0;
            if (load) begin
                quo_r <= dividend;
                dsr_r <= divisor;
                rem_r <= '0;
                cnt_r <= '0;
                run_r <= 1'b1;
            end else if (run_r) begin
                if (!trial[W+1]) begin
                    rem_r <= trial[W:0];
                    quo_r <= {quo_r[W-2:0], 1'b1};
                end else begin
                    rem_r <= shifted;
                    quo_r <= {quo_r[W-2:0], 1'b0};
                end
                cnt_r <= cnt_r + 1'b1;
                if (cnt_r == CNT_W'(W - 1)) begin
                    run_r <= 1'b0;
                    fin_r <= 1'b1;
                end
            end
        end
    end

    assign fin      = fin_r;
    assign quotient = quo_r;

endmodule

// File: rtl/thermo_code_interp.sv
module thermo_code_interp
    import thermo_interp_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int CODE_W = BP_CODE_W,
    parameter int TEMP_W = BP_TEMP_W,
    parameter int DIV_W  = 32,
    parameter int N_BP   = BP_COUNT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [IN_W-1:0]          code_in,
    output logic                     busy,
    output logic                     done,
    output logic                     invalid,
    output logic signed [TEMP_W-1:0] temp
);

    localparam int IDX_W = $clog2(N_BP);
    localparam int PW    = IDX_W + 2;
    localparam logic [PW-1:0] HI_INIT  = PW'(N_BP - 1);
    localparam logic [PW-1:0] MID_INIT = PW'((N_BP - 1) / 2);

    conv_state_t state_r, state_nx;

    logic [CODE_W-1:0]        code_r;
    logic                     inv_r;
    logic [PW-1:0]            lo_r, hi_r, mid_r;
    logic [PW-1:0]            mid_up, mid_dn;
    logic signed [TEMP_W-1:0] base_r, temp_r;

    logic [IDX_W-1:0]         idx_a, idx_b;
    logic [CODE_W-1:0]        code_a, code_b;
    logic signed [TEMP_W-1:0] temp_a, temp_b;

    logic                     out_of_range;
    logic                     at_floor;
    logic                     hit;
    logic                     div_load, div_fin;
    logic [DIV_W-1:0]         div_num, div_den, div_quo;

    // Probe index and its upper neighbour (index 0 stands in when the probe is at 0).
    assign idx_a = mid_r[IDX_W-1:0];
    assign idx_b = (mid_r == '0) ? '0 : IDX_W'(mid_r - 1'b1);

    tci_bp_rom #(
        .N_BP   (N_BP),
        .CODE_W (CODE_W),
        .TEMP_W (TEMP_W)
    ) u_rom (
        .idx_a  (idx_a),
        .idx_b  (idx_b),
        .code_a (code_a),
        .temp_a (temp_a),
        .code_b (code_b),
        .temp_b (temp_b)
    );

    always_comb begin
        out_of_range = |code_in[IN_W-1:CODE_W];
        at_floor     = (mid_r == '0) || (lo_r > hi_r);
        hit          = (code_r >= code_a) && (code_r < code_b);
        mid_up       = (mid_r + 1'b1 + hi_r) >> 1;
        mid_dn       = (lo_r + mid_r - 1'b1) >> 1;
        div_num      = DIV_W'(unsigned'(temp_a - temp_b)) * (DIV_W'(code_b) - DIV_W'(code_r));
        div_den      = DIV_W'(code_b) - DIV_W'(code_a);
    end

    tci_restoring_div #(
        .W (DIV_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .dividend (div_num),
        .divisor  (div_den),
        .fin      (div_fin),
        .quotient (div_quo)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_r <= ST_IDLE;
        else        state_r <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state_r;
        unique case (state_r)
            ST_IDLE:
                if (start) state_nx = out_of_range ? ST_FINISH : ST_SEARCH;
            ST_SEARCH:
                if (at_floor)  state_nx = ST_FINISH;
                else if (hit)  state_nx = ST_DIVIDE;
            ST_DIVIDE:
                if (div_fin)   state_nx = ST_FINISH;
            ST_FINISH:
                state_nx = ST_IDLE;
            default:
                state_nx = ST_IDLE;
        endcase
    end

    // Search bounds and result datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_r <= '0;
            inv_r  <= 1'b0;
            lo_r   <= '0;
            hi_r   <= '0;
            mid_r  <= '0;
            base_r <= '0;
            temp_r <= '0;
        end else begin
            unique case (state_r)
                ST_IDLE: begin
                    if (start) begin
                        code_r <= code_in[CODE_W-1:0];
                        inv_r  <= out_of_range;
                        lo_r   <= '0;
                        hi_r   <= HI_INIT;
                        mid_r  <= MID_INIT;
                        temp_r <= '0;
                    end
                end
                ST_SEARCH: begin
                    if (at_floor) begin
                        temp_r <= temp_b;
                    end else if (hit) begin
                        base_r <= temp_b;
                    end else if (code_r < code_a) begin
                        lo_r  <= mid_r + 1'b1;
                        mid_r <= mid_up;
                    end else begin
                        hi_r  <= mid_r - 1'b1;
                        mid_r <= mid_dn;
                    end
                end
                ST_DIVIDE: begin
                    if (div_fin) temp_r <= base_r + $signed(TEMP_W'(div_quo));
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        div_load = (state_r == ST_SEARCH) && !at_floor && hit;
        busy     = (state_r != ST_IDLE);
        done     = (state_r == ST_FINISH);
        invalid  = (state_r == ST_FINISH) && inv_r;
        temp     = temp_r;
    end

endmodule

// File: rtl/thermo_code_interp_chk.sv
module thermo_code_interp_chk #(
    parameter int TEMP_W = 32,
    parameter int T_MIN  = -40000,
    parameter int T_MAX  = 125000
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     busy,
    input logic                     done,
    input logic                     invalid,
    input logic signed [TEMP_W-1:0] temp
);

    // R6: done lasts a single cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: an accepted start makes the block busy
    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7: busy holds until the done cycle
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R10: idle again right after done
    a_r10_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R1: an invalid result carries zero
    a_r1_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && invalid) |-> (temp == '0));

    // R9: valid results stay inside the table span
    a_r9_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !invalid) |-> (temp >= TEMP_W'(T_MIN) && temp <= TEMP_W'(T_MAX)));

    // R8: strobes are quiet in reset
    always_comb begin
        if (!rst_n) a_r8_reset_quiet: assert (!done && !invalid);
    end

endmodule

bind thermo_code_interp thermo_code_interp_chk #(
    .TEMP_W (TEMP_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .invalid (invalid),
    .temp    (temp)
);

// File: tb/thermo_code_interp_bench.sv
module thermo_code_interp_bench;

    localparam int IN_W   = 16;
    localparam int TEMP_W = 32;
    localparam int DIV_W  = 32;
    localparam int MAX_LAT = DIV_W + 16;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     start = 1'b0;
    logic [IN_W-1:0]          code_in = '0;
    logic                     busy, done, invalid;
    logic signed [TEMP_W-1:0] temp;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    thermo_code_interp u_thermo_code_interp (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .code_in (code_in),
        .busy    (busy),
        .done    (done),
        .invalid (invalid),
        .temp    (temp)
    );

    // Bench copy of the breakpoint table, from the requirements
    function automatic int ref_code(input int i);
        int c [36] = '{4095, 3800, 3792, 3783, 3774, 3765, 3756, 3747, 3737, 3728,
                       3718, 3708, 3698, 3688, 3678, 3667, 3656, 3645, 3634, 3623,
                       3611, 3600, 3588, 3575, 3563, 3550, 3537, 3524, 3510, 3496,
                       3482, 3467, 3452, 3437, 3421, 0};
        return c[i];
    endfunction

    function automatic int ref_temp(input int i);
        if (i <= 1)  return -40000;
        if (i >= 34) return 125000;
        return -40000 + (i - 1) * 5000;
    endfunction

    // Linear-scan model of R3, R4 and R5
    function automatic int ref_result(input int code);
        if (code >= 4095) return -40000;
        for (int i = 1; i < 36; i++) begin
            if (code >= ref_code(i) && code < ref_code(i - 1))
                return ref_temp(i - 1) +
                       ((ref_temp(i) - ref_temp(i - 1)) * (ref_code(i - 1) - code)) /
                       (ref_code(i - 1) - ref_code(i));
        end
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    // One request; returns the result, the latency and whether done pulsed once
    task automatic convert(input logic [IN_W-1:0] c, output int t, output bit inv,
                           output int lat, output bit got);
        @(negedge clk);
        while (busy) @(negedge clk);
        start   = 1'b1;
        code_in = c;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        got = 1'b0;
        t   = 0;
        inv = 1'b0;
        while (lat <= MAX_LAT && !got) begin
            if (done) begin
                got = 1'b1;
                t   = temp;
                inv = invalid;
            end else begin
                @(negedge clk);
                lat++;
            end
        end
        @(negedge clk);
        check(!done, "R6", "done width", done, 0);
        check(!busy, "R10", "busy after done", busy, 0);
    endtask

    task automatic valid_case(input int c, input string req);
        int t, lat; bit inv, got;
        convert(IN_W'(c), t, inv, lat, got);
        check(got, "R6", "done seen", got, 1);
        check(!inv, req, "invalid flag", inv, 0);
        check(t == ref_result(c), req, $sformatf("temp for code %0d", c), t, ref_result(c));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int t, lat, dn;
        bit inv, got;
        process::self().srandom(32'h5EED_1234);

        // R8: reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && !invalid, "R8", "strobes in reset", {busy, done, invalid}, 0);
        check(temp == 0, "R8", "temp in reset", temp, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && temp == 0, "R8", "idle after reset", busy, 0);

        // R2: named points and every breakpoint
        valid_case(3728, "R2");
        check(temp == 0, "R2", "3728 gives 0", temp, 0);
        valid_case(3600, "R2");
        check(temp == 60000, "R2", "3600 gives 60000", temp, 60000);
        valid_case(3496, "R2");
        check(temp == 100000, "R2", "3496 gives 100000", temp, 100000);
        for (int i = 1; i < 35; i++) valid_case(ref_code(i), "R2");

        // R4 and R5: both ends
        valid_case(4095, "R4");
        valid_case(4094, "R4");
        valid_case(3801, "R4");
        valid_case(3420, "R5");
        valid_case(0, "R5");
        valid_case(1, "R5");

        // R1: out-of-range codes, with the latency of one cycle
        convert(16'h1000, t, inv, lat, got);
        check(got && inv, "R1", "invalid on 0x1000", inv, 1);
        check(t == 0, "R1", "temp on invalid", t, 0);
        check(lat == 1, "R1", "invalid latency", lat, 1);
        convert(16'hFFFF, t, inv, lat, got);
        check(got && inv && t == 0, "R1", "invalid on 0xFFFF", inv, 1);

        // R7: a start during busy is ignored
        @(negedge clk);
        start = 1'b1; code_in = 16'd3600;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; code_in = 16'hF000;
        @(negedge clk);
        start = 1'b0; code_in = 16'd0;
        dn = 0; t = 0; inv = 1'b0;
        for (int k = 0; k < 2 * MAX_LAT; k++) begin
            if (done) begin dn++; t = temp; inv = invalid; end
            @(negedge clk);
        end
        check(dn == 1, "R7", "done count with stray start", dn, 1);
        check(t == 60000 && !inv, "R7", "result with stray start", t, 60000);

        // R3, R6, R9, R10: random codes, mostly in range
        for (int n = 0; n < 700; n++) begin
            int c;
            if ($urandom_range(0, 9) == 0) begin
                c = $urandom_range(4096, 65535);
                convert(IN_W'(c), t, inv, lat, got);
                check(got && inv && t == 0, "R1", $sformatf("random invalid %0d", c), t, 0);
            end else begin
                if ($urandom_range(0, 1) == 0) c = $urandom_range(3400, 3820);
                else                           c = $urandom_range(0, 4095);
                convert(IN_W'(c), t, inv, lat, got);
                check(got && lat <= MAX_LAT, "R6", "latency bound", lat, MAX_LAT);
                check(!inv, "R3", "random valid flag", inv, 0);
                check(t == ref_result(c), "R3", $sformatf("random code %0d", c), t, ref_result(c));
                check(t >= -40000 && t <= 125000, "R9", "range", t, 0);
            end
        end

        summary();
        $finish;
    end

endmodule